// File: doc/BRIEF.md
# Dual-Modulus Alternating Clock Divider

This block derives a slow clock, such as one near 32.768 kHz, from a fast reference clock. It reaches a fractional average ratio by alternating between two integer divide lengths. A first phase repeats one length a programmed number of times. A second phase then repeats the other length its own number of times, and the cycle repeats without end. When dual operation is off, only the first length is used.

Two 32-bit control words set the lengths, the repeat counts, the dual enable, a bypass, and separate input and output gates. Because the gates are separate, software can start the counters, let them settle, and only then open the output. The block gives two outputs in the reference domain. One is a divided clock that is high for the first half of each period. The other is a one-cycle enable pulse on the first cycle of each period.

Every length and repeat field holds its true value minus one. New field values are held in a shadow copy and take effect only at a period boundary.

Top module: `dual_mod_clkdiv`

## Requirements
- R1: Control word 0 decodes as follows: first length field at bits [11:0], second length field at bits [23:12], dual enable at bit 28, output gate at bit 30 and input gate at bit 31.
- R2: Control word 1 decodes as follows: first repeat field at bits [11:0], second repeat field at bits [23:12] and bypass at bit 24.
- R3: With dual enable clear and bypass clear, every period lasts (first length field + 1) reference cycles.
- R4: With dual enable set, the block runs (first repeat field + 1) periods of (first length field + 1) cycles. It then runs (second repeat field + 1) periods of (second length field + 1) cycles, and repeats. The total over one full pattern equals the weighted sum of the two lengths.
- R5: In a period of L cycles, div_clk_o is high for the first floor(L/2) cycles and low for the rest. tick_o is high only on the first cycle of each period.
- R6: With bypass set and both gates open, div_clk_o follows the reference clock and tick_o is high on every cycle.
- R7: With the output gate closed, tick_o and div_clk_o stay low while the counters keep running. When the gate reopens, ticks stay on the same period grid.
- R8: With the input gate closed, both outputs are low and the sequencer returns to the first cycle of the first phase. Opening the gate starts a first-phase period in that same cycle.
- R9: A change to a length field made mid-period does not alter the current period. It applies from the next period.
- R10: After reset, with both gates closed, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg0_i | input | 32 | Control word 0: lengths, dual enable, gates |
| cfg1_i | input | 32 | Control word 1: repeat counts, bypass |
| tick_o | output | 1 | One-cycle enable pulse at the start of each period |
| div_clk_o | output | 1 | Divided clock, high for the first half of each period |

## Verification
The bench sweeps every small combination of the two lengths and two repeat counts. For each combination it measures each period's length and high time against an arithmetic model, including periods only one cycle long, where the divided clock never goes high.

A design that compared the repeat counter off by one would show one extra or one missing period per phase. Swapping the length fields would make the phase lengths trade places.

The bench closes the input gate during a second-phase period and then reopens it. A design that forgot to clear the phase would resume with the short length. The bench also rewrites a length mid-period; an unshadowed design would truncate or stretch that period. It closes the output gate and checks that the tick grid holds, which shows whether the counters were wrongly frozen. Finally it samples the bypass output on both clock levels.

// File: rtl/dmd_pkg.sv
package dmd_pkg;

    localparam int FIELD_W = 12;
    localparam int LEN_W   = FIELD_W + 1;

    localparam int A_LO_POS   = 0;
    localparam int B_LO_POS   = 12;
    localparam int DUAL_POS   = 28;
    localparam int OGATE_POS  = 30;
    localparam int IGATE_POS  = 31;
    localparam int BYPASS_POS = 24;

    typedef enum logic {
        PH_A = 1'b0,
        PH_B = 1'b1
    } phase_e;

    typedef struct packed {
        logic [FIELD_W-1:0] len_a;
        logic [FIELD_W-1:0] len_b;
        logic [FIELD_W-1:0] rep_a;
        logic [FIELD_W-1:0] rep_b;
        logic               dual;
    } div_cfg_t;

    typedef struct packed {
        logic in_gate;
        logic out_gate;
        logic bypass;
    } gate_t;

    function automatic div_cfg_t decode_cfg(input logic [31:0] w0, input logic [31:0] w1);
        div_cfg_t c;
        c.len_a = w0[A_LO_POS +: FIELD_W];
        c.len_b = w0[B_LO_POS +: FIELD_W];
        c.rep_a = w1[A_LO_POS +: FIELD_W];
        c.rep_b = w1[B_LO_POS +: FIELD_W];
        c.dual  = w0[DUAL_POS];
        return c;
    endfunction

    function automatic gate_t decode_gates(input logic [31:0] w0, input logic [31:0] w1);
        gate_t g;
        g.in_gate  = w0[IGATE_POS];
        g.out_gate = w0[OGATE_POS];
        g.bypass   = w1[BYPASS_POS];
        return g;
    endfunction

endpackage

// File: rtl/dmd_cfg_shadow.sv
module dmd_cfg_shadow
    import dmd_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     load_i,
    input  div_cfg_t cfg_i,
    output div_cfg_t cfg_o
);
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cfg_o <= '0;
        end else if (load_i) begin
            cfg_o <= cfg_i;
        end
    end
endmodule

// File: rtl/dmd_period_ctr.sv
module dmd_period_ctr
    import dmd_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clr_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [LEN_W-1:0] cnt_o,
    output logic             last_o,
    output logic             high_o
);
    assign last_o = (cnt_o == len_i - LEN_W'(1));
    assign high_o = (cnt_o < (len_i >> 1));

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            cnt_o <= '0;
        end else if (last_o) begin
            cnt_o <= '0;
        end else begin
            cnt_o <= cnt_o + LEN_W'(1);
        end
    end
endmodule

// File: rtl/dmd_phase_seq.sv
module dmd_phase_seq
    import dmd_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     clr_i,
    input  logic     adv_i,
    input  div_cfg_t cur_i,
    input  logic     next_dual_i,
    output phase_e   phase_o
);
    logic [FIELD_W-1:0] rep_q;
    logic [FIELD_W-1:0] limit;

    assign limit = (phase_o == PH_A) ? cur_i.rep_a : cur_i.rep_b;

    always_ff @(posedge clk_i) begin
        if (rst_i || clr_i) begin
            phase_o <= PH_A;
            rep_q   <= '0;
        end else if (adv_i) begin
            if (!next_dual_i || !cur_i.dual) begin
                phase_o <= PH_A;
                rep_q   <= '0;
            end else if (rep_q == limit) begin
                phase_o <= (phase_o == PH_A) ? PH_B : PH_A;
                rep_q   <= '0;
            end else begin
                rep_q   <= rep_q + FIELD_W'(1);
            end
        end
    end
endmodule

// File: rtl/dual_mod_clkdiv.sv
module dual_mod_clkdiv
    import dmd_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic [31:0] cfg0_i,
    input  logic [31:0] cfg1_i,
    output logic        tick_o,
    output logic        div_clk_o
);
    div_cfg_t         cfg_new;
    div_cfg_t         cfg_cur;
    gate_t            gates;
    phase_e           phase;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] cur_len;
    logic             last;
    logic             high;
    logic             running;
    logic             period_end;

    assign cfg_new    = decode_cfg(cfg0_i, cfg1_i);
    assign gates      = decode_gates(cfg0_i, cfg1_i);
    assign running    = gates.in_gate;
    assign period_end = running && last;
    assign cur_len    = {1'b0, (phase == PH_B) ? cfg_cur.len_b : cfg_cur.len_a} + LEN_W'(1);

    dmd_cfg_shadow u_shadow (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .load_i (!running || period_end),
        .cfg_i  (cfg_new),
        .cfg_o  (cfg_cur)
    );

    dmd_period_ctr u_ctr (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .clr_i  (!running),
        .len_i  (cur_len),
        .cnt_o  (cnt),
        .last_o (last),
        .high_o (high)
    );

    dmd_phase_seq u_seq (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .clr_i       (!running),
        .adv_i       (period_end),
        .cur_i       (cfg_cur),
        .next_dual_i (cfg_new.dual),
        .phase_o     (phase)
    );

    assign tick_o    = gates.in_gate && gates.out_gate && (gates.bypass || cnt == '0);
    assign div_clk_o = gates.in_gate && gates.out_gate && (gates.bypass ? clk_i : high);
endmodule

// File: rtl/dual_mod_clkdiv_chk.sv
module dual_mod_clkdiv_chk
    import dmd_pkg::*;
(
    input logic             clk_i,
    input logic             rst_i,
    input logic [31:0]      w0,
    input logic             tick,
    input logic             div_clk,
    input logic [LEN_W-1:0] cnt,
    input logic [LEN_W-1:0] len,
    input phase_e           phase
);
    assert_gate_quiet_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        !w0[OGATE_POS] |-> (!tick && !div_clk));

    assert_in_gate_restart_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        !w0[IGATE_POS] |=> (cnt == '0 && phase == PH_A));

    assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt < len);

    assert_period_wrap_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (w0[IGATE_POS] && cnt == len - LEN_W'(1)) |=> cnt == '0);

    assert_len_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (w0[IGATE_POS] && cnt != len - LEN_W'(1)) |=> $stable(len));
endmodule

bind dual_mod_clkdiv dual_mod_clkdiv_chk u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .w0      (cfg0_i),
    .tick    (tick_o),
    .div_clk (div_clk_o),
    .cnt     (cnt),
    .len     (cur_len),
    .phase   (phase)
);

// File: tb/dual_mod_clkdiv_tb.sv
module dual_mod_clkdiv_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] w0  = '0;
    logic [31:0] w1  = '0;
    logic        tick;
    logic        dclk;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_mod_clkdiv u_dut (
        .clk_i     (clk),
        .rst_i     (rst),
        .cfg0_i    (w0),
        .cfg1_i    (w1),
        .tick_o    (tick),
        .div_clk_o (dclk)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R1 field positions: len_a [11:0], len_b [23:12], dual 28, out gate 30, in gate 31
    function automatic logic [31:0] mk0(int a, int b, bit dual, bit og, bit ig);
        logic [31:0] w = '0;
        w[11:0]  = 12'(a);
        w[23:12] = 12'(b);
        w[28]    = dual;
        w[30]    = og;
        w[31]    = ig;
        return w;
    endfunction

    // R2 field positions: rep_a [11:0], rep_b [23:12], bypass 24
    function automatic logic [31:0] mk1(int ra, int rb, bit byp);
        logic [31:0] w = '0;
        w[11:0]  = 12'(ra);
        w[23:12] = 12'(rb);
        w[24]    = byp;
        return w;
    endfunction

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    // Called at a sample point where tick was seen; ends at the next tick.
    task automatic meas(output int len, output int hi);
        len = 1;
        hi  = int'(dclk);
        forever begin
            step();
            if (tick) break;
            len++;
            hi += int'(dclk);
            if (len > 5000) break;
        end
    endtask

    // Load configuration with the input gate closed, then open it.
    task automatic start(input logic [31:0] c0, input logic [31:0] c1);
        step();
        w0 = c0;
        w0[31] = 1'b0;
        w1 = c1;
        step();
        w0[31] = 1'b1;
        #1;
        chk(tick == 1'b1, "R8 tick on gate open", int'(tick), 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int len, hi, sum, exp_len, plen, ref_sum;
        repeat (3) @(negedge clk);
        #1;
        chk(tick == 0 && dclk == 0, "R10 reset outputs", int'(tick) + int'(dclk), 0);
        rst = 1'b0;
        step();
        chk(tick == 0 && dclk == 0, "R10 idle after reset", int'(tick) + int'(dclk), 0);

        // R3 single-mode sweep
        for (int a = 0; a < 16; a++) begin
            start(mk0(a, 0, 0, 1, 1), mk1(0, 0, 0));
            for (int p = 0; p < 3; p++) begin
                meas(len, hi);
                chk(len == a + 1, "R3 single period", len, a + 1);
                chk(hi == (a + 1) / 2, "R5 high time", hi, (a + 1) / 2);
            end
        end

        // R4 dual-mode sweep
        for (int a = 0; a < 6; a++)
        for (int b = 0; b < 4; b++)
        for (int ra = 0; ra < 3; ra++)
        for (int rb = 0; rb < 3; rb++) begin
            start(mk0(a, b, 1, 1, 1), mk1(ra, rb, 0));
            plen    = (ra + 1) + (rb + 1);
            ref_sum = (ra + 1) * (a + 1) + (rb + 1) * (b + 1);
            for (int pat = 0; pat < 2; pat++) begin
                sum = 0;
                for (int i = 0; i < plen; i++) begin
                    exp_len = (i < ra + 1) ? a + 1 : b + 1;
                    meas(len, hi);
                    sum += len;
                    chk(len == exp_len, "R4 dual period", len, exp_len);
                    chk(hi == exp_len / 2, "R5 dual high time", hi, exp_len / 2);
                end
                chk(sum == ref_sum, "R4 pattern total", sum, ref_sum);
            end
        end

        // R8 close input gate during second phase, then reopen
        start(mk0(5, 2, 1, 1, 1), mk1(0, 2, 0));
        meas(len, hi);
        chk(len == 6, "R8 first phase", len, 6);
        meas(len, hi);
        chk(len == 3, "R8 second phase", len, 3);
        w0[31] = 1'b0;
        #1;
        for (int k = 0; k < 4; k++) begin
            chk(tick == 0 && dclk == 0, "R8 gated low", int'(tick) + int'(dclk), 0);
            step();
        end
        w0[31] = 1'b1;
        #1;
        chk(tick == 1'b1, "R8 restart tick", int'(tick), 1);
        meas(len, hi);
        chk(len == 6, "R8 restart in first phase", len, 6);

        // R9 mid-period length change
        start(mk0(7, 0, 0, 1, 1), mk1(0, 0, 0));
        len = 1;
        repeat (3) begin
            step();
            len++;
        end
        w0[11:0] = 12'd2;
        forever begin
            step();
            if (tick || len > 100) break;
            len++;
        end
        chk(len == 8, "R9 current period kept", len, 8);
        meas(len, hi);
        chk(len == 3, "R9 new length next period", len, 3);

        // R7 output gate closed while counting, grid kept
        start(mk0(3, 0, 0, 1, 1), mk1(0, 0, 0));
        w0[30] = 1'b0;
        for (int k = 1; k <= 10; k++) begin
            step();
            chk(tick == 0 && dclk == 0, "R7 output gated", int'(tick) + int'(dclk), 0);
        end
        w0[30] = 1'b1;
        #1;
        chk(tick == 0, "R7 no tick off-grid", int'(tick), 0);
        step();
        chk(tick == 0, "R7 no tick off-grid", int'(tick), 0);
        step();
        chk(tick == 1, "R7 tick on grid", int'(tick), 1);

        // R6 bypass
        w1[24] = 1'b1;
        for (int k = 0; k < 4; k++) begin
            step();
            chk(dclk == 0 && tick == 1, "R6 bypass clk low", int'(dclk), 0);
            @(posedge clk);
            #1;
            chk(dclk == 1, "R6 bypass clk high", int'(dclk), 1);
        end
        w0[30] = 1'b0;
        @(posedge clk);
        #1;
        chk(dclk == 0, "R7 bypass gated", int'(dclk), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule